// File: doc/BRIEF.md
# Wavefront Lane Permutation Unit

This block moves 32-bit values between the lanes of a 64-lane SIMD wavefront. Each cycle it takes a source vector, an "old" vector and a 9-bit control code. The control code picks one permutation pattern: a permute inside each group of four lanes, a shift or rotate inside each 16-lane row, a shift or rotate of the whole wave by one lane, a reversal inside a row or half-row, or a copy of the last lane of a row into the rows that follow it. A 4-bit row mask and a 4-bit bank mask (a bank is four adjacent lanes of a row) decide which lanes are written. Every lane that is not written passes its old value through.

When a pattern would read from outside its row or outside the wave, the lane has no source. Such a lane takes zero when the zero-fill input is set, and keeps its old value otherwise. The permutation network is combinational. A single output register captures the result, so the answer appears one clock edge after the inputs. An asynchronous active-low reset clears that register.

Top module: `lane_perm_unit`

## Requirements
- R1: `result_o` is all zeros while `rst_n` is low, and it clears as soon as reset asserts, without waiting for a clock edge. Otherwise `result_o` shows the result for the inputs present at the previous rising edge, and it does not change between edges.
- R2: Codes 0x000 to 0x0FF select the quad permute. Lane i takes source lane 4*(i/4)+q, where q is control bits [2*(i%4)+1 : 2*(i%4)]. The code 0x0E4 is the identity.
- R3: Codes 0x101 to 0x10F select row shift left by n = code[3:0]. Lane k of a row takes lane k+n of the same row. The lane has no source when k+n > 15.
- R4: Codes 0x111 to 0x11F select row shift right by n = code[3:0]. Lane k of a row takes lane k-n of the same row. The lane has no source when k < n.
- R5: Codes 0x121 to 0x12F select row rotate right by n = code[3:0]. Lane k takes lane (k-n) mod 16 of the same row.
- R6: Four codes act on the whole wave by one lane:
  - 0x130: lane i takes lane i+1. Lane 63 has no source.
  - 0x134: lane i takes lane (i+1) mod 64.
  - 0x138: lane i takes lane i-1. Lane 0 has no source.
  - 0x13C: lane i takes lane (i-1) mod 64.
- R7: Code 0x140 reverses the lanes inside each 16-lane row (lane k takes lane 15-k). Code 0x141 reverses the lanes inside each 8-lane group.
- R8: Code 0x142 copies lane 16r-1 into every lane of row r, for r = 1 to 3; row 0 has no source. Code 0x143 copies lane 31 into rows 2 and 3; rows 0 and 1 have no source.
- R9: A written lane that has no source outputs zero when `bound_zero_i` is 1, and outputs its old value when it is 0.
- R10: A lane outputs its old value unless both of these bits are 1: `row_mask_i` bit i/16, and `bank_mask_i` bit (i%16)/4.
- R11: Every other code outputs the old vector on all lanes. This covers shift and rotate codes with amount 0 (0x100, 0x110, 0x120), the 0x13x values not listed in R6, 0x144 to 0x14F, and 0x150 to 0x1FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 2048 | Source vector; lane i is bits [32i+31:32i] |
| old_i | input | 2048 | Value kept by lanes that are not written |
| ctrl_i | input | 9 | Permutation control code |
| row_mask_i | input | 4 | Write enable for each 16-lane row |
| bank_mask_i | input | 4 | Write enable for each 4-lane bank within a row |
| bound_zero_i | input | 1 | 1: a lane with no source outputs zero; 0: it keeps its old value |
| result_o | output | 2048 | Registered result vector |

## Verification
The only register between the inputs and `result_o` is the output register. Every permuted, masked or zero-filled lane is therefore due at the first rising edge after the inputs settle. The bench changes its inputs on a falling edge, lets one rising edge pass, and compares all 64 lanes on the next falling edge. One directed check samples just before the rising edge, to confirm that the previous result is still held. The reset checks differ: the clear is asynchronous, so the bench samples the output a fraction of a cycle after `rst_n` falls, before any edge.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;
  typedef enum logic [3:0] {
    PM_NONE,
    PM_QUAD,
    PM_ROW_SHL,
    PM_ROW_SHR,
    PM_ROW_ROR,
    PM_WAVE_SHL,
    PM_WAVE_ROL,
    PM_WAVE_SHR,
    PM_WAVE_ROR,
    PM_MIRROR,
    PM_HMIRROR,
    PM_BCAST15,
    PM_BCAST31
  } perm_mode_e;
endpackage

// File: rtl/lane_perm_decode.sv
module lane_perm_decode
  import lane_perm_pkg::*;
(
  input  logic [8:0] ctrl_i,
  output perm_mode_e mode_o,
  output logic [3:0] shamt_o,
  output logic [7:0] quad_sel_o
);
  assign shamt_o    = ctrl_i[3:0];
  assign quad_sel_o = ctrl_i[7:0];

  always_comb begin
    mode_o = PM_NONE;
    if (!ctrl_i[8]) begin
      mode_o = PM_QUAD;
    end else begin
      case (ctrl_i[7:4])
        4'h0: if (ctrl_i[3:0] != 4'd0) mode_o = PM_ROW_SHL;
        4'h1: if (ctrl_i[3:0] != 4'd0) mode_o = PM_ROW_SHR;
        4'h2: if (ctrl_i[3:0] != 4'd0) mode_o = PM_ROW_ROR;
        4'h3: begin
          case (ctrl_i[3:0])
            4'h0:    mode_o = PM_WAVE_SHL;
            4'h4:    mode_o = PM_WAVE_ROL;
            4'h8:    mode_o = PM_WAVE_SHR;
            4'hC:    mode_o = PM_WAVE_ROR;
            default: mode_o = PM_NONE;
          endcase
        end
        4'h4: begin
          case (ctrl_i[3:0])
            4'h0:    mode_o = PM_MIRROR;
            4'h1:    mode_o = PM_HMIRROR;
            4'h2:    mode_o = PM_BCAST15;
            4'h3:    mode_o = PM_BCAST31;
            default: mode_o = PM_NONE;
          endcase
        end
        default: mode_o = PM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lane_perm_xbar.sv
module lane_perm_xbar
  import lane_perm_pkg::*;
#(
  parameter int LANES = 64,
  parameter int W     = 32,
  parameter int ROW   = 16
) (
  input  logic [LANES*W-1:0] src_i,
  input  perm_mode_e         mode_i,
  input  logic [3:0]         shamt_i,
  input  logic [7:0]         quad_sel_i,
  output logic [LANES*W-1:0] pick_o,
  output logic [LANES-1:0]   hit_o
);
  localparam int LW   = $clog2(LANES);
  localparam int HALF = ROW / 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int K  = g % ROW;
    localparam int RB = g - K;
    localparam int HB = g - (g % HALF);
    localparam int QB = g - (g % 4);

    int         s;
    int         sh;
    logic       ok;
    logic [LW-1:0] idx;

    always_comb begin
      sh = int'(shamt_i);
      s  = g;
      ok = 1'b1;
      case (mode_i)
        PM_QUAD:     s = QB + int'(quad_sel_i[2*(g%4) +: 2]);
        PM_ROW_SHL:  begin s = g + sh; ok = (K + sh) < ROW; end
        PM_ROW_SHR:  begin s = g - sh; ok = K >= sh; end
        PM_ROW_ROR:  s = RB + ((K - sh + ROW) % ROW);
        PM_WAVE_SHL: begin s = g + 1; ok = (g < LANES - 1); end
        PM_WAVE_ROL: s = (g + 1) % LANES;
        PM_WAVE_SHR: begin s = g - 1; ok = (g > 0); end
        PM_WAVE_ROR: s = (g + LANES - 1) % LANES;
        PM_MIRROR:   s = RB + ROW - 1 - K;
        PM_HMIRROR:  s = HB + HALF - 1 - (g % HALF);
        PM_BCAST15:  begin s = RB - 1; ok = (g >= ROW); end
        PM_BCAST31:  begin s = 2*ROW - 1; ok = (g >= 2*ROW); end
        default:     ok = 1'b0;
      endcase
      idx = ok ? LW'(s) : LW'(g);
    end

    assign pick_o[g*W +: W] = src_i[idx*W +: W];
    assign hit_o[g]         = ok;
  end
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit
  import lane_perm_pkg::*;
#(
  parameter int LANES = 64,
  parameter int W     = 32,
  parameter int ROW   = 16,
  parameter int BANK  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES*W-1:0]    src_i,
  input  logic [LANES*W-1:0]    old_i,
  input  logic [8:0]            ctrl_i,
  input  logic [LANES/ROW-1:0]  row_mask_i,
  input  logic [ROW/BANK-1:0]   bank_mask_i,
  input  logic                  bound_zero_i,
  output logic [LANES*W-1:0]    result_o
);
  localparam int NROW  = LANES / ROW;
  localparam int NBANK = ROW / BANK;

  perm_mode_e         mode;
  logic [3:0]         shamt;
  logic [7:0]         qsel;
  logic [LANES*W-1:0] pick;
  logic [LANES-1:0]   hit;
  logic [LANES-1:0]   lane_en;
  logic [LANES*W-1:0] result_d;
  logic [LANES*W-1:0] result_q;

  lane_perm_decode u_dec (
    .ctrl_i     (ctrl_i),
    .mode_o     (mode),
    .shamt_o    (shamt),
    .quad_sel_o (qsel)
  );

  lane_perm_xbar #(.LANES(LANES), .W(W), .ROW(ROW)) u_xbar (
    .src_i      (src_i),
    .mode_i     (mode),
    .shamt_i    (shamt),
    .quad_sel_i (qsel),
    .pick_o     (pick),
    .hit_o      (hit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_wb
    assign lane_en[g] = row_mask_i[g/ROW] & bank_mask_i[(g%ROW)/BANK] & (mode != PM_NONE);

    always_comb begin
      if (!lane_en[g])       result_d[g*W +: W] = old_i[g*W +: W];
      else if (hit[g])       result_d[g*W +: W] = pick[g*W +: W];
      else if (bound_zero_i) result_d[g*W +: W] = '0;
      else                   result_d[g*W +: W] = old_i[g*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end

  assign result_o = result_q;

  // ---------------- assertions ----------------
  logic chk_armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r10_masked_lane_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && !($past(row_mask_i[g/ROW]) && $past(bank_mask_i[(g%ROW)/BANK]))
      |-> result_o[g*W +: W] == $past(old_i[g*W +: W]));

    a_r9_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(lane_en[g] && !hit[g] && bound_zero_i)
      |-> result_o[g*W +: W] == '0);
  end

  a_r11_unknown_code_passes_old: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed && $past(mode == PM_NONE) |-> result_o == $past(old_i));

  a_r2_quad_identity: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed && $past(ctrl_i == 9'h0E4 && (&row_mask_i) && (&bank_mask_i))
    |-> result_o == $past(src_i));

  a_r6_wave_rol_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed && $past(ctrl_i == 9'h134 && row_mask_i[NROW-1] && bank_mask_i[NBANK-1])
    |-> result_o[(LANES-1)*W +: W] == $past(src_i[W-1:0]));
endmodule

// File: tb/lane_perm_unit_test.sv
module lane_perm_unit_test;
  localparam int LANES = 64;
  localparam int W     = 32;
  localparam int NV    = 23;

  logic                 clk;
  logic                 rst_n;
  logic [LANES*W-1:0]   src_v;
  logic [LANES*W-1:0]   old_v;
  logic [8:0]           ctrl;
  logic [3:0]           rm;
  logic [3:0]           bm;
  logic                 bz;
  logic [LANES*W-1:0]   result;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cur_seed = 1;

  lane_perm_unit uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_v), .old_i(old_v), .ctrl_i(ctrl),
    .row_mask_i(rm), .bank_mask_i(bm), .bound_zero_i(bz), .result_o(result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {ctrl[8:0], row_mask[3:0], bank_mask[3:0], zero_fill}
  localparam logic [17:0] VEC [NV] = '{
    {9'h0E4, 4'hF, 4'hF, 1'b0},  // R2 identity
    {9'h01B, 4'hF, 4'hF, 1'b0},  // R2 reverse quad
    {9'h103, 4'hF, 4'hF, 1'b0},  // R3 keep old at edge
    {9'h10F, 4'hF, 4'hF, 1'b1},  // R3 R9 zero fill
    {9'h112, 4'hF, 4'hF, 1'b1},  // R4
    {9'h11F, 4'hF, 4'hF, 1'b0},  // R4
    {9'h125, 4'hF, 4'hF, 1'b0},  // R5
    {9'h121, 4'hF, 4'hF, 1'b1},  // R5
    {9'h130, 4'hF, 4'hF, 1'b1},  // R6
    {9'h134, 4'hF, 4'hF, 1'b0},  // R6
    {9'h138, 4'hF, 4'hF, 1'b0},  // R6
    {9'h13C, 4'hF, 4'hF, 1'b1},  // R6
    {9'h140, 4'hF, 4'hF, 1'b0},  // R7
    {9'h141, 4'hF, 4'hF, 1'b0},  // R7
    {9'h142, 4'hF, 4'hF, 1'b1},  // R8
    {9'h143, 4'hF, 4'hF, 1'b0},  // R8
    {9'h103, 4'h5, 4'hF, 1'b1},  // R10 row mask
    {9'h0E4, 4'hF, 4'h6, 1'b0},  // R10 bank mask
    {9'h0E4, 4'h0, 4'hF, 1'b0},  // R10 all rows off
    {9'h100, 4'hF, 4'hF, 1'b1},  // R11 amount zero
    {9'h131, 4'hF, 4'hF, 1'b1},  // R11
    {9'h144, 4'hF, 4'hF, 1'b1},  // R11
    {9'h1A0, 4'hF, 4'hF, 1'b1}   // R11
  };

  function automatic logic [31:0] src_of(int j, int seed);
    return (32'(seed) << 24) ^ (32'(j) * 32'h0001_0203) ^ 32'h0080_0000;
  endfunction

  function automatic logic [31:0] old_of(int j, int seed);
    return 32'hF000_0000 | (32'(seed) << 12) | 32'(j);
  endfunction

  // Reference model written from the requirements
  function automatic logic [31:0] model(logic [8:0] c, logic [3:0] r, logic [3:0] b,
                                        logic z, int i, int seed);
    int k = i % 16;
    int base = i - k;
    int n = int'(c[3:0]);
    int sl = i;
    bit valid = 1;
    bit known = 1;
    if (c[8] == 1'b0) sl = (i / 4) * 4 + int'((c >> (2 * (i % 4))) & 9'd3);
    else if (c > 9'h100 && c <= 9'h10F) begin sl = i + n; valid = (k + n <= 15); end
    else if (c > 9'h110 && c <= 9'h11F) begin sl = i - n; valid = (k >= n); end
    else if (c > 9'h120 && c <= 9'h12F) sl = base + (k + 16 - n) % 16;
    else if (c == 9'h130) begin sl = i + 1; valid = (i != 63); end
    else if (c == 9'h134) sl = (i + 1) % 64;
    else if (c == 9'h138) begin sl = i - 1; valid = (i != 0); end
    else if (c == 9'h13C) sl = (i + 63) % 64;
    else if (c == 9'h140) sl = base + 15 - k;
    else if (c == 9'h141) sl = (i / 8) * 8 + 7 - (i % 8);
    else if (c == 9'h142) begin sl = base - 1; valid = (i >= 16); end
    else if (c == 9'h143) begin sl = 31; valid = (i >= 32); end
    else known = 0;
    if (!known || !r[i/16] || !b[k/4]) return old_of(i, seed);
    if (!valid) return z ? 32'd0 : old_of(i, seed);
    return src_of(sl, seed);
  endfunction

  task automatic load(logic [8:0] c, logic [3:0] r, logic [3:0] b, logic z, int seed);
    ctrl = c; rm = r; bm = b; bz = z; cur_seed = seed;
    for (int j = 0; j < LANES; j++) begin
      src_v[j*W +: W] = src_of(j, seed);
      old_v[j*W +: W] = old_of(j, seed);
    end
  endtask

  task automatic check_all(string tag);
    int first = -1;
    logic [31:0] exp_w = '0;
    logic [31:0] got_w = '0;
    for (int j = 0; j < LANES; j++) begin
      logic [31:0] e;
      e = model(ctrl, rm, bm, bz, j, cur_seed);
      if (result[j*W +: W] !== e && first < 0) begin
        first = j; exp_w = e; got_w = result[j*W +: W];
      end
    end
    total++;
    if (first >= 0) begin
      bad++;
      $display("FAIL %s ctrl=%h lane %0d: actual=%h expected=%h", tag, ctrl, first, got_w, exp_w);
    end
  endtask

  task automatic check_word(string tag, int lane, logic [31:0] e);
    total++;
    if (result[lane*W +: W] !== e) begin
      bad++;
      $display("FAIL %s lane %0d: actual=%h expected=%h", tag, lane, result[lane*W +: W], e);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tag;
    rst_n = 1'b0;
    load(9'h0E4, 4'hF, 4'hF, 1'b0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    total++;
    if (result !== '0) begin
      bad++;
      $display("FAIL R1 reset: actual=%h expected=0", result[31:0]);
    end
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      load(VEC[v][17:9], VEC[v][8:5], VEC[v][4:1], VEC[v][0], v + 1);
      @(posedge clk);
      @(negedge clk);
      case (v)
        0, 1:                     tag = "R2";
        2, 3:                     tag = "R3_R9";
        4, 5:                     tag = "R4";
        6, 7:                     tag = "R5";
        8, 9, 10, 11:             tag = "R6";
        12, 13:                   tag = "R7";
        14, 15:                   tag = "R8";
        16, 17, 18:               tag = "R10";
        default:                  tag = "R11";
      endcase
      check_all(tag);
    end

    // R2: reverse quad, spot value
    @(negedge clk);
    load(9'h01B, 4'hF, 4'hF, 1'b0, 40);
    @(posedge clk); @(negedge clk);
    check_word("R2 quad 0x1B", 1, src_of(2, 40));

    // R8: broadcast 15 spot value
    @(negedge clk);
    load(9'h142, 4'hF, 4'hF, 1'b1, 41);
    @(posedge clk); @(negedge clk);
    check_word("R8 bcast15 row1", 20, src_of(15, 41));
    check_word("R8 R9 bcast15 row0", 3, 32'd0);

    // R1: output held until the edge
    @(negedge clk);
    load(9'h140, 4'hF, 4'hF, 1'b0, 42);
    #2.0;
    check_word("R1 hold before edge", 20, src_of(15, 41));
    @(posedge clk); @(negedge clk);
    check_word("R1 after edge", 0, src_of(15, 42));

    // R9: shift right without zero fill keeps old at row start
    @(negedge clk);
    load(9'h114, 4'hF, 4'hF, 1'b0, 43);
    @(posedge clk); @(negedge clk);
    check_word("R9 keep old", 17, old_of(17, 43));
    check_word("R4 moved", 21, src_of(17, 43));

    // R1: asynchronous clear
    #0.5;
    rst_n = 1'b0;
    #0.5;
    total++;
    if (result !== '0) begin
      bad++;
      $display("FAIL R1 async clear: actual=%h expected=0", result[31:0]);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule